// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block moves a processor core from ordinary execution into a handler. Three events can start an entry: a memory-translation miss, a software break that carries a trap number, or an external interrupt described by a 32-bit pending mask. The block picks one event, works out its vector number and reads the handler address from a vector table through a simple read port with a valid/ready handshake.

When the read completes, the block presents three values in a single-cycle done pulse: the new program counter, the return address to save, and the rewritten status word. The core writes all three in that cycle, so the entry takes effect as one step. Instruction decode, address translation and the register file stay in the core.

The status rewrite keeps the two top bits and moves the low twenty bits up by ten places. This pushes the live flag set into a saved field and leaves a cleared flag field for the handler.

Top module: `exc_entry_seq`

## Requirements
- R1: The vector read address is `vbase_i + 4 * vector`. `rd_valid_o` stays high and `rd_addr_o` stays unchanged from the cycle after acceptance until a cycle with `rd_ready_i` high, which completes the read.
- R2: For a software break the vector is `trap_num_i` and the return address is `pc_i + 2`.
- R3: For a translation miss the vector is 4 and the return address is `pc_i`, so the faulting instruction runs again.
- R4: For an external interrupt the vector is 0x30 plus the index of the highest set bit of `pend_i`, and the return address is `pc_i`.
- R5: An interrupt request is ignored when `pend_i` is zero or when the enable flag, status bit 4 by default, is clear. In that case `busy_o`, `rd_valid_o` and `done_o` stay low.
- R6: The new status value keeps bits 31:30 of the status sampled at acceptance, holds its old bits 19:0 in bits 29:10, and has bits 9:0 cleared.
- R7: When several requests arrive in the same cycle, a translation miss wins, then a software break, then an interrupt.
- R8: A request seen while the block is idle is accepted at that clock edge. `busy_o` is high from the next cycle through the done cycle, and requests seen while busy are ignored.
- R9: `done_o` is high for exactly one cycle, the cycle after the completing read. In that cycle `new_pc_o` equals the word read, and `ret_addr_o` and `new_status_o` are valid.
- R10: After reset `busy_o`, `rd_valid_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pc_i | input | 32 | Current program counter |
| vbase_i | input | 32 | Vector table base address |
| status_i | input | 32 | Current status/condition-code word |
| trap_num_i | input | 8 | Trap number carried with a break |
| miss_req_i | input | 1 | Translation-miss request |
| brk_req_i | input | 1 | Software-break request |
| irq_req_i | input | 1 | External-interrupt request |
| pend_i | input | 32 | Pending-interrupt mask |
| rd_valid_o | output | 1 | Vector read request valid |
| rd_addr_o | output | 32 | Vector read address |
| rd_ready_i | input | 1 | Read completes; data valid in the same cycle |
| rd_data_i | input | 32 | Read data (handler address) |
| busy_o | output | 1 | Entry in progress |
| done_o | output | 1 | One-cycle commit strobe |
| new_pc_o | output | 32 | Handler program counter |
| ret_addr_o | output | 32 | Return address to save |
| new_status_o | output | 32 | Rewritten status word |

## Verification
The embedded properties check the timing rules on every cycle. They cover the read request staying high with a steady address while it is stalled, the done strobe lasting one cycle and falling inside the busy window, and a disabled or empty interrupt request never raising busy. The vector arithmetic, the return-address offset per cause, the status bit movement and the priority order among simultaneous requests are value checks. Only the bench scenarios can show these, by comparing the read address and the committed outputs against values it computes itself.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
   typedef enum logic [1:0] {
      CS_NONE = 2'd0,
      CS_MISS = 2'd1,
      CS_BRK  = 2'd2,
      CS_IRQ  = 2'd3
   } exc_cause_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FETCH = 2'd1,
      ST_DONE  = 2'd2
   } seq_state_e;
endpackage

// File: rtl/exc_msb_find.sv
module exc_msb_find #(
   parameter int W     = 32,
   parameter int IDX_W = $clog2(W)
) (
   input  logic [W-1:0]     bits_i,
   output logic [IDX_W-1:0] idx_o,
   output logic             any_o
);
   generate
      if (W < 2) begin : g_bad_width
         $error("exc_msb_find: W must be at least 2");
      end
   endgenerate

   always_comb begin
      idx_o = '0;
      for (int i = 0; i < W; i++) begin
         if (bits_i[i]) idx_o = IDX_W'(i);
      end
   end

   assign any_o = |bits_i;
endmodule

// File: rtl/exc_cause_arb.sv
module exc_cause_arb
   import exc_entry_pkg::*;
#(
   parameter int          IRQ_W    = 32,
   parameter int          VEC_W    = 8,
   parameter logic [7:0]  MISS_VEC = 8'd4,
   parameter logic [7:0]  IRQ_BASE = 8'h30
) (
   input  logic             miss_i,
   input  logic             brk_i,
   input  logic             irq_i,
   input  logic             irq_en_i,
   input  logic [IRQ_W-1:0] pend_i,
   input  logic [VEC_W-1:0] trap_i,
   output logic             take_o,
   output exc_cause_e       cause_o,
   output logic [VEC_W-1:0] vec_o
);
   localparam int IDX_W = $clog2(IRQ_W);

   logic [IDX_W-1:0] top_idx;
   logic             pend_any;

   generate
      if (IRQ_BASE + IRQ_W - 1 >= (1 << VEC_W)) begin : g_bad_vec
         $error("exc_cause_arb: VEC_W too narrow for interrupt vectors");
      end
   endgenerate

   exc_msb_find #(.W(IRQ_W), .IDX_W(IDX_W)) u_msb (
      .bits_i(pend_i),
      .idx_o (top_idx),
      .any_o (pend_any)
   );

   always_comb begin
      cause_o = CS_NONE;
      vec_o   = '0;
      if (miss_i) begin
         cause_o = CS_MISS;
         vec_o   = VEC_W'(MISS_VEC);
      end else if (brk_i) begin
         cause_o = CS_BRK;
         vec_o   = trap_i;
      end else if (irq_i && pend_any && irq_en_i) begin
         cause_o = CS_IRQ;
         vec_o   = VEC_W'(IRQ_BASE) + VEC_W'(top_idx);
      end
   end

   assign take_o = (cause_o != CS_NONE);
endmodule

// File: rtl/exc_status_shift.sv
module exc_status_shift #(
   parameter int DATA_W = 32,
   parameter int KEEP   = 2,
   parameter int SHIFT  = 10
) (
   input  logic [DATA_W-1:0] old_i,
   output logic [DATA_W-1:0] new_o
);
   localparam int MOVE = DATA_W - KEEP - SHIFT;

   logic [SHIFT-1:0] unused_mid;

   generate
      if (MOVE < 1 || KEEP < 0) begin : g_bad_split
         $error("exc_status_shift: field split does not fit DATA_W");
      end
   endgenerate

   assign unused_mid = old_i[DATA_W-KEEP-1 -: SHIFT];

   generate
      if (KEEP > 0) begin : g_keep
         assign new_o = {old_i[DATA_W-1 -: KEEP], old_i[MOVE-1:0], {SHIFT{1'b0}}};
      end else begin : g_nokeep
         assign new_o = {old_i[MOVE-1:0], {SHIFT{1'b0}}};
      end
   endgenerate
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
   import exc_entry_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int IRQ_W   = 32,
   parameter int VEC_W   = 8,
   parameter int IE_BIT  = 4,
   parameter int BRK_INC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] pc_i,
   input  logic [DATA_W-1:0] vbase_i,
   input  logic [DATA_W-1:0] status_i,
   input  logic [VEC_W-1:0]  trap_num_i,
   input  logic              miss_req_i,
   input  logic              brk_req_i,
   input  logic              irq_req_i,
   input  logic [IRQ_W-1:0]  pend_i,
   output logic              rd_valid_o,
   output logic [DATA_W-1:0] rd_addr_o,
   input  logic              rd_ready_i,
   input  logic [DATA_W-1:0] rd_data_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [DATA_W-1:0] new_pc_o,
   output logic [DATA_W-1:0] ret_addr_o,
   output logic [DATA_W-1:0] new_status_o
);
   localparam int PAD_W = DATA_W - VEC_W - 2;

   generate
      if (IE_BIT >= DATA_W) begin : g_bad_ie
         $error("exc_entry_seq: IE_BIT outside status word");
      end
      if (PAD_W < 0) begin : g_bad_pad
         $error("exc_entry_seq: VEC_W too wide for DATA_W");
      end
   endgenerate

   seq_state_e        state_q;
   exc_cause_e        cause;
   logic              take;
   logic [VEC_W-1:0]  vec;
   logic [DATA_W-1:0] shifted;
   logic [DATA_W-1:0] addr_q, ret_q, stat_q, pc_q;

   exc_cause_arb #(.IRQ_W(IRQ_W), .VEC_W(VEC_W)) u_arb (
      .miss_i  (miss_req_i),
      .brk_i   (brk_req_i),
      .irq_i   (irq_req_i),
      .irq_en_i(status_i[IE_BIT]),
      .pend_i  (pend_i),
      .trap_i  (trap_num_i),
      .take_o  (take),
      .cause_o (cause),
      .vec_o   (vec)
   );

   exc_status_shift #(.DATA_W(DATA_W)) u_shift (
      .old_i(status_i),
      .new_o(shifted)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
         ret_q   <= '0;
         stat_q  <= '0;
         pc_q    <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (take) begin
               state_q <= ST_FETCH;
               addr_q  <= vbase_i + {{PAD_W{1'b0}}, vec, 2'b00};
               ret_q   <= (cause == CS_BRK) ? pc_i + DATA_W'(BRK_INC) : pc_i;
               stat_q  <= shifted;
            end
            ST_FETCH: if (rd_ready_i) begin
               state_q <= ST_DONE;
               pc_q    <= rd_data_i;
            end
            ST_DONE:  state_q <= ST_IDLE;
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   assign rd_valid_o   = (state_q == ST_FETCH);
   assign rd_addr_o    = addr_q;
   assign busy_o       = (state_q != ST_IDLE);
   assign done_o       = (state_q == ST_DONE);
   assign new_pc_o     = pc_q;
   assign ret_addr_o   = ret_q;
   assign new_status_o = stat_q;

   AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_addr_o))); // R1
   AST_IRQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && irq_req_i && !miss_req_i && !brk_req_i &&
       (pend_i == '0 || !status_i[IE_BIT])) |=> !busy_o); // R5
   AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> busy_o); // R8
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R9
   AST_DONE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> $past(rd_valid_o && rd_ready_i)); // R9
endmodule

// File: tb/sim_exc_entry_seq.sv
`timescale 1ns/1ps
module sim_exc_entry_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] pc_i = '0, vbase_i = 32'h0000_8000, status_i = '0;
   logic [7:0]  trap_num_i = '0;
   logic        miss_req_i = 1'b0, brk_req_i = 1'b0, irq_req_i = 1'b0;
   logic [31:0] pend_i = '0;
   logic        rd_valid_o, rd_ready_i = 1'b0;
   logic [31:0] rd_addr_o, rd_data_i;
   logic        busy_o, done_o;
   logic [31:0] new_pc_o, ret_addr_o, new_status_o;

   int checks = 0;
   int failures = 0;

   always #2.5 clk = ~clk;

   assign rd_data_i = {rd_addr_o[15:0] ^ 16'hBEEF, rd_addr_o[31:16]};

   exc_entry_seq u0 (.*);

   // entry: {miss,brk,irq}[3] trap[8] stall[4] pend[32] status[32] pc[32]
   localparam int NV = 8;
   localparam logic [110:0] VEC_TAB [NV] = '{
      {3'b100, 8'h00, 4'd0, 32'h0,         32'hC00F_FFFF, 32'h0000_1000},
      {3'b010, 8'h07, 4'd2, 32'h0,         32'h4001_2345, 32'h0000_2002},
      {3'b001, 8'h00, 4'd1, 32'h0000_0001, 32'h0000_0010, 32'h0000_3000},
      {3'b001, 8'h00, 4'd3, 32'h8000_0010, 32'h8000_0010, 32'h1234_5678},
      {3'b111, 8'h11, 4'd0, 32'h0000_0100, 32'hFFFF_FFFF, 32'h0000_4000},
      {3'b011, 8'h22, 4'd1, 32'h0000_0100, 32'h0000_0010, 32'h0000_5000},
      {3'b001, 8'h00, 4'd0, 32'h0,         32'h0000_0010, 32'h0000_6000},
      {3'b001, 8'h00, 4'd0, 32'h0000_0400, 32'hFFFF_FFEF, 32'h0000_7000}
   };

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_word(input logic [31:0] a);
      return {a[15:0] ^ 16'hBEEF, a[31:16]};
   endfunction

   function automatic logic [31:0] exp_status(input logic [31:0] s);
      logic [31:0] r;
      r = '0;
      for (int b = 0; b < 20; b++) r[b + 10] = s[b];
      r[31] = s[31];
      r[30] = s[30];
      return r;
   endfunction

   task automatic run_entry(input logic [110:0] e, input bit poke_busy);
      bit m, b, q, take;
      logic [7:0] trap, vecn;
      logic [3:0] stall;
      logic [31:0] pend, st, pc, exp_addr, exp_ret;
      string tag;
      {m, b, q, trap, stall, pend, st, pc} = e;
      take = 1'b0; vecn = '0; exp_ret = pc; tag = "R5";
      if (m) begin take = 1'b1; vecn = 8'd4; tag = "R3/R7"; end
      else if (b) begin take = 1'b1; vecn = trap; exp_ret = pc + 32'd2; tag = "R2/R7"; end
      else if (q && st[4]) begin
         for (int i = 31; i >= 0; i--)
            if (!take && pend[i]) begin take = 1'b1; vecn = 8'h30 + 8'(i); tag = "R4"; end
      end
      exp_addr = vbase_i + {22'd0, vecn, 2'b00};
      @(negedge clk);
      miss_req_i = m; brk_req_i = b; irq_req_i = q;
      trap_num_i = trap; pend_i = pend; status_i = st; pc_i = pc; rd_ready_i = 1'b0;
      @(negedge clk);
      miss_req_i = 1'b0; brk_req_i = 1'b0; irq_req_i = 1'b0;
      if (!take) begin
         for (int k = 0; k < 3; k++) begin
            check(!busy_o && !rd_valid_o && !done_o, "R5 ignored irq", {29'd0, busy_o, rd_valid_o, done_o}, 32'd0);
            @(negedge clk);
         end
         return;
      end
      check(busy_o, "R8 busy after accept", {31'd0, busy_o}, 32'd1);
      check(rd_valid_o && rd_addr_o == exp_addr, {tag, " R1 address"}, rd_addr_o, exp_addr);
      if (poke_busy) begin
         miss_req_i = 1'b1; pc_i = 32'hDEAD_0000; status_i = 32'h0;
      end
      for (int k = 0; k < int'(stall); k++) begin
         @(negedge clk);
         check(rd_valid_o && rd_addr_o == exp_addr && !done_o, "R1 hold while stalled", rd_addr_o, exp_addr);
      end
      miss_req_i = 1'b0;
      rd_ready_i = 1'b1;
      @(negedge clk);
      rd_ready_i = 1'b0;
      check(done_o && busy_o, "R9 done pulse", {30'd0, done_o, busy_o}, 32'd3);
      check(new_pc_o == exp_word(exp_addr), "R9 new pc", new_pc_o, exp_word(exp_addr));
      check(ret_addr_o == exp_ret, {tag, " return address"}, ret_addr_o, exp_ret);
      check(new_status_o == exp_status(st), "R6 status", new_status_o, exp_status(st));
      @(negedge clk);
      check(!done_o && !busy_o && !rd_valid_o, "R9/R8 back to idle", {30'd0, done_o, busy_o}, 32'd0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      check(!busy_o && !rd_valid_o && !done_o, "R10 reset state", {29'd0, busy_o, rd_valid_o, done_o}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy_o && !done_o, "R10 idle after reset", {30'd0, busy_o, done_o}, 32'd0);
      for (int v = 0; v < NV; v++) run_entry(VEC_TAB[v], 1'b0);
      // R8: a request raised during the fetch must not alter the entry in flight
      run_entry({3'b010, 8'h3F, 4'd2, 32'h0, 32'h0001_0010, 32'h0000_9000}, 1'b1);
      @(negedge clk);
      check(!busy_o, "R8 request while busy dropped", {31'd0, busy_o}, 32'd0);
      // R4: lowest pending bit only gives vector 0x30
      vbase_i = 32'h0001_0004;
      run_entry({3'b001, 8'h00, 4'd0, 32'h0000_0001, 32'h0000_0010, 32'h0000_A000}, 1'b0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule